// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block enciphers one 128-bit block under a 128-bit key, one cipher round per clock, with all sixteen state bytes substituted in parallel. Round keys are derived on the fly from the previous round key, so no expanded key schedule is stored. The initial key whitening happens when a block is accepted, and the ten rounds then follow on the next ten clock edges.

A static select input chooses the byte substitution used inside the rounds. The first choice is the standard 256-entry field-inverse-plus-affine substitution. The second is a compact substitution in which the upper nibble of each byte is looked up in one 16-entry table and the lower nibble in another. Both tables are module parameters. Key expansion always uses the standard substitution, whatever the select says.

The input side is a valid/ready handshake. A block is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the core is idle, so a producer facing back-pressure must hold its key, text and `in_valid` until ready returns. The output side has no back-pressure: `out_done` pulses for one cycle, and `out_text` holds the ciphertext until the next block is accepted.

Top module: `aes128_iter_enc`

## Requirements
- R1: After reset `in_ready` is 1, `out_done` is 0 and `out_text` is all zeros.
- R2: A block is accepted only on an edge where `in_valid` and `in_ready` are both 1. `in_valid` pulses while the core is busy are ignored and do not change the result of the block in flight.
- R3: `in_ready` is 0 from the edge that accepts a block until `out_done` rises. `out_done` is high for exactly one cycle, 10 clock edges after the accepting edge.
- R4: With `sub_mode`=0 the result is standard AES-128. Key 000102..0f with plaintext 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: With `sub_mode`=1, each round replaces every state byte b by {P[b[7:4]], Q[b[3:0]]}. Entry u of a table is bits [4u+3:4u] of the parameter `P_TAB` or `Q_TAB`. Key expansion still uses the standard substitution.
- R6: `out_text` keeps the ciphertext unchanged while no new block is accepted.
- R7: Byte i of the state is bits [127-8i:120-8i] of the 128-bit word. Bytes are column-major (row = i mod 4, column = i div 4). Row r is rotated left by r columns, and the last of the 10 rounds skips the column mix.
- R8: `sub_mode` may change between blocks. Each block is enciphered in the mode held during its run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_mode | input | 1 | 0 = standard byte substitution, 1 = split nibble tables |
| in_valid | input | 1 | Key and plaintext presented |
| in_ready | output | 1 | Core idle, block will be accepted |
| in_key | input | 128 | Cipher key, byte 0 in the top bits |
| in_text | input | 128 | Plaintext, byte 0 in the top bits |
| out_done | output | 1 | One-cycle pulse when the ciphertext is valid |
| out_text | output | 128 | Ciphertext, held until the next accepted block |

## Verification
The assertions assume that `in_valid` is only ever acted on through `in_ready`, and that `sub_mode` does not change while a block is in flight. The stimulus changes the mode only between blocks. Its only busy-time activity is deliberate `in_valid` pulses while `in_ready` is low. The latency and hold properties also rely on `in_valid` being low on the cycle `out_done` rises, which the stimulus keeps by dropping `in_valid` well before the tenth round.

// File: rtl/aes128_pkg.sv
package aes128_pkg;
  localparam int NBYTE  = 16;
  localparam int NROUND = 10;
  localparam int CNT_W  = $clog2(NROUND + 1);

  typedef logic [7:0] byte_t;

  // multiply by x in GF(2^8), reduction polynomial 0x11b
  function automatic byte_t xt(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gmul(input byte_t a, input byte_t b);
    byte_t r;
    byte_t x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = xt(x);
    end
    return r;
  endfunction

  // inverse as a^254 (0 maps to 0), then affine transform
  function automatic byte_t sbox(input byte_t a);
    byte_t r;
    byte_t sq;
    byte_t inv;
    logic [7:0] e;
    e  = 8'd254;
    r  = 8'h01;
    sq = a;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gmul(r, sq);
      sq = gmul(sq, sq);
    end
    inv = r;
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_sub_layer.sv
module aes_sub_layer
  import aes128_pkg::*;
#(
  parameter logic [63:0] P_TAB = 64'h7095c6a38bf21d4e,
  parameter logic [63:0] Q_TAB = 64'ha50cd27943b6e81f
) (
  input  logic         mode,
  input  logic [127:0] din,
  output logic [127:0] dout
);
  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    byte_t b;
    byte_t full_v;
    byte_t split_v;
    assign b       = din[127-8*g -: 8];
    assign full_v  = sbox(b);
    assign split_v = {P_TAB[{b[7:4], 2'b00} +: 4], Q_TAB[{b[3:0], 2'b00} +: 4]};
    assign dout[127-8*g -: 8] = mode ? split_v : full_v;
  end
endmodule

// File: rtl/aes_round_xform.sv
module aes_round_xform
  import aes128_pkg::*;
#(
  parameter logic [63:0] P_TAB = 64'h7095c6a38bf21d4e,
  parameter logic [63:0] Q_TAB = 64'ha50cd27943b6e81f
) (
  input  logic         mode,
  input  logic         last,
  input  logic [127:0] st_in,
  input  logic [127:0] rkey,
  output logic [127:0] st_out
);
  logic [127:0] subbed;
  logic [127:0] shifted;
  logic [127:0] mixed;

  aes_sub_layer #(.P_TAB(P_TAB), .Q_TAB(Q_TAB)) u_sub (
    .mode (mode),
    .din  (subbed_src(st_in)),
    .dout (subbed)
  );

  function automatic logic [127:0] subbed_src(input logic [127:0] v);
    return v;
  endfunction

  // row r of column c takes the byte from column (c+r) mod 4
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign shifted[127-8*(4*c+r) -: 8] = subbed[127-8*(4*((c+r)%4)+r) -: 8];
    end
    byte_t a0, a1, a2, a3;
    assign a0 = shifted[127-32*c -: 8];
    assign a1 = shifted[119-32*c -: 8];
    assign a2 = shifted[111-32*c -: 8];
    assign a3 = shifted[103-32*c -: 8];
    assign mixed[127-32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
    assign mixed[119-32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
    assign mixed[111-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
    assign mixed[103-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
  end

  assign st_out = (last ? shifted : mixed) ^ rkey;
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes128_pkg::*;
(
  input  logic [127:0] key_in,
  input  logic [7:0]   rcon,
  output logic [127:0] key_out
);
  logic [31:0] w0, w1, w2, w3, t;
  logic [31:0] n0, n1, n2, n3;

  assign {w0, w1, w2, w3} = key_in;
  assign t  = {sbox(w3[23:16]) ^ rcon, sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])};
  assign n0 = w0 ^ t;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign key_out = {n0, n1, n2, n3};
endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
  import aes128_pkg::*;
#(
  parameter logic [63:0] P_TAB = 64'h7095c6a38bf21d4e,
  parameter logic [63:0] Q_TAB = 64'ha50cd27943b6e81f
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sub_mode,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_key,
  input  logic [127:0] in_text,
  output logic         out_done,
  output logic [127:0] out_text
);
  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(NROUND);

  logic             busy;
  logic [CNT_W-1:0] rnd;
  logic [127:0]     st;
  logic [127:0]     rk;
  logic [7:0]       rc;
  logic [127:0]     rk_next;
  logic [127:0]     st_next;
  logic             accept;

  assign accept = in_valid && !busy;

  aes_key_step u_key (
    .key_in  (rk),
    .rcon    (rc),
    .key_out (rk_next)
  );

  aes_round_xform #(.P_TAB(P_TAB), .Q_TAB(Q_TAB)) u_round (
    .mode   (sub_mode),
    .last   (rnd == LAST_RND),
    .st_in  (st),
    .rkey   (rk_next),
    .st_out (st_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rnd      <= '0;
      st       <= '0;
      rk       <= '0;
      rc       <= 8'h01;
      out_done <= 1'b0;
    end else begin
      out_done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        rnd  <= CNT_W'(1);
        st   <= in_text ^ in_key;
        rk   <= in_key;
        rc   <= 8'h01;
      end else if (busy) begin
        st  <= st_next;
        rk  <= rk_next;
        rc  <= xt(rc);
        rnd <= rnd + CNT_W'(1);
        if (rnd == LAST_RND) begin
          busy     <= 1'b0;
          out_done <= 1'b1;
        end
      end
    end
  end

  assign in_ready = !busy;
  assign out_text = st;
endmodule

// File: rtl/aes128_iter_enc_chk.sv
module aes128_iter_enc_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_done,
  input logic [127:0] out_text
);
  localparam int NR = aes128_pkg::NROUND;
  localparam logic [4:0] DONE_AT = 5'(NR + 1);

  logic [4:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (in_valid && in_ready) since <= 5'd1;
    else if (since != 5'd0 && since != 5'd31) since <= since + 5'd1;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (since == DONE_AT));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(out_text));
endmodule

bind aes128_iter_enc aes128_iter_enc_chk u_chk (.*);

// File: tb/sim_aes128_iter_enc.sv
`timescale 1ns/1ps
module sim_aes128_iter_enc;
  localparam logic [63:0] PT = 64'h7095c6a38bf21d4e;
  localparam logic [63:0] QT = 64'ha50cd27943b6e81f;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] in_key = '0;
  logic [127:0] in_text = '0;
  logic out_done;
  logic [127:0] out_text;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] tb_sb [256];

  always #5 clk = ~clk;

  aes128_iter_enc #(.P_TAB(PT), .Q_TAB(QT)) u0 (.*);

  function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p,
                                           input logic cm);
    logic [31:0] w [4];
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [31:0] tmp;
    logic [7:0] rc;
    logic [127:0] res;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ k[127-8*i -: 8];
    rc = 8'h01;
    for (int rd = 1; rd <= 10; rd++) begin
      tmp = {tb_sb[w[3][23:16]], tb_sb[w[3][15:8]], tb_sb[w[3][7:0]], tb_sb[w[3][31:24]]};
      tmp = tmp ^ {rc, 24'h0};
      w[0] = w[0] ^ tmp; w[1] = w[1] ^ w[0]; w[2] = w[2] ^ w[1]; w[3] = w[3] ^ w[2];
      rc = tmul(rc, 8'h02);
      for (int i = 0; i < 16; i++)
        s[i] = cm ? {PT[4*s[i][7:4] +: 4], QT[4*s[i][3:0] +: 4]} : tb_sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
      for (int c = 0; c < 4; c++) begin
        if (rd < 10) begin
          s[4*c]   = tmul(t[4*c],8'h2) ^ tmul(t[4*c+1],8'h3) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ tmul(t[4*c+1],8'h2) ^ tmul(t[4*c+2],8'h3) ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ tmul(t[4*c+2],8'h2) ^ tmul(t[4*c+3],8'h3);
          s[4*c+3] = tmul(t[4*c],8'h3) ^ t[4*c+1] ^ t[4*c+2] ^ tmul(t[4*c+3],8'h2);
        end else begin
          for (int r = 0; r < 4; r++) s[4*c+r] = t[4*c+r];
        end
        for (int r = 0; r < 4; r++) s[4*c+r] = s[4*c+r] ^ w[c][31-8*r -: 8];
      end
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] k, input logic [127:0] p, input logic m,
                        input bit jam, output logic [127:0] ct, output int lat,
                        output bit rdy_ok);
    @(negedge clk);
    sub_mode = m; in_key = k; in_text = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0; rdy_ok = 1'b1;
    while (!out_done && lat < 40) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (!out_done && in_ready) rdy_ok = 1'b0;
      if (jam && lat >= 2 && lat <= 5) begin
        in_valid = 1'b1; in_key = ~k; in_text = ~p;
      end else begin
        in_valid = 1'b0;
      end
    end
    ct = out_text;
  endtask

  task automatic do_case(input logic [127:0] k, input logic [127:0] p, input logic m,
                         input bit jam, input string req);
    logic [127:0] ct;
    logic [127:0] ex;
    int lat;
    bit rdy;
    ex = ref_enc(k, p, m);
    run_op(k, p, m, jam, ct, lat, rdy);
    chk(ct === ex, req, ct, ex);
    chk(lat == 10 && rdy, "R3 latency/ready", 128'(lat), 128'd10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] inv;
    logic [7:0] o;
    logic [127:0] k;
    logic [127:0] p;
    logic [127:0] ct;
    logic [127:0] hold;
    void'($urandom(32'd7141));
    for (int a = 0; a < 256; a++) begin
      inv = 8'h00;
      for (int b = 1; b < 256; b++) if (tmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
      tb_sb[a] = o;
    end

    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_done === 1'b0, "R1 ready/done after reset",
        {126'd0, in_ready, out_done}, 128'd2);
    chk(out_text === '0, "R1 out_text after reset", out_text, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R7: published vector, also fixes byte order and last-round behaviour
    k = 128'h000102030405060708090a0b0c0d0e0f;
    p = 128'h00112233445566778899aabbccddeeff;
    chk(ref_enc(k, p, 1'b0) === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 bench model vector",
        ref_enc(k, p, 1'b0), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    do_case(k, p, 1'b0, 1'b0, "R4 R7 known vector");
    ct = out_text;
    chk(ct === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 literal ciphertext", ct,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // R6: output held while idle
    hold = out_text;
    repeat (6) @(negedge clk);
    chk(out_text === hold && in_ready && !out_done, "R6 hold while idle", out_text, hold);

    // R5: split tables, key expansion standard
    do_case(k, p, 1'b1, 1'b0, "R5 split mode vector");

    // corner patterns
    do_case('0, '0, 1'b0, 1'b0, "R4 zero block std");
    do_case('0, '0, 1'b1, 1'b0, "R5 zero block split");
    do_case('1, '1, 1'b0, 1'b0, "R4 ones block std");
    do_case('1, '1, 1'b1, 1'b0, "R5 ones block split");

    // R2: pulses while busy ignored
    do_case(k, ~p, 1'b0, 1'b1, "R2 busy start ignored std");
    do_case(~k, p, 1'b1, 1'b1, "R2 busy start ignored split");

    // R8: alternating modes, random data
    for (int n = 0; n < 30; n++) begin
      k = {$urandom, $urandom, $urandom, $urandom};
      p = {$urandom, $urandom, $urandom, $urandom};
      do_case(k, p, n[0], n % 5 == 3, "R8 random mixed mode");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule